// File: doc/BRIEF.md
# Limp-Home Watchdog with Sequenced Trigger

This block is a fail-safe supervisor. While its enable input is high, a cycle timer runs towards a timeout. Software keeps the system out of fail-safe mode by writing a 2-bit trigger value that must match a sequence counter kept inside the block. Each accepted write restarts the timer after a short settle delay, and the counter then steps to its next value. The next write must therefore carry a new value, so a stuck routine that repeats one write cannot keep the watchdog alive.

A write with the wrong value sets a lock. While the lock is set, no write is accepted. Software must clear the lock explicitly and then write the correct value. If the timer expires, a limp-home output goes high, its output enable is asserted, and the trigger logic returns to its defaults. Nothing that software does can leave limp-home. Only a low level on the enable input releases it. All inputs are synchronous to `clk_i`.

Top module: `wdg_limp`

## Requirements
- R1: After reset, and on every edge where `enable_i` is low, the outputs read: `cnt_o` = 2'b11, `lock_o` = 0, `limp_o` = 0 and `limp_oe_o` = 0.
- R2: A trigger write is accepted when all of these hold: `enable_i` is high, the block is not in limp-home, the lock is clear, no restart delay is pending, and `trig_val_i` equals `cnt_o`. When a write is accepted, `cnt_o` increments by one (3 wraps to 0) exactly DISCH_CYC edges after the edge that takes the write.
- R3: A trigger write whose value differs from `cnt_o`, made while enabled and not in limp-home, makes `lock_o` read 1 after that edge.
- R4: While `lock_o` is 1, a trigger write with the matching value is not accepted, and `cnt_o` does not advance.
- R5: Pulsing `lock_clr_i` clears the lock at the next edge. A trigger write in the same cycle is judged against the lock as it was before the clear: a matching write is not accepted, and a wrong write leaves the lock set.
- R6: `limp_o` rises on the TIMEOUT-th edge after enable goes high, or after the restart delay ends, when no write is accepted in between. A write accepted in the last cycle before expiry prevents limp-home.
- R7: Once `limp_o` is 1, it stays 1 for as long as `enable_i` is high. During that time trigger writes and `lock_clr_i` have no effect, and `cnt_o` and `lock_o` hold their defaults (2'b11 and 0).
- R8: When `enable_i` is low at an edge, limp-home is left and the trigger state returns to its R1 values at that edge.
- R9: A matching trigger write made during the restart delay is ignored. It does not start a second restart and does not add an increment.
- R10: `limp_oe_o` equals `limp_o` at all times, so the limp-home pin is high impedance whenever the block is not in limp-home.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Watchdog enable level; a low level also releases limp-home |
| trig_we_i | input | 1 | Trigger write strobe |
| trig_val_i | input | CNT_W | Trigger value carried by the write |
| lock_clr_i | input | 1 | Software lock-clear strobe |
| cnt_o | output | CNT_W | Sequence counter readback |
| lock_o | output | 1 | Lock readback |
| limp_o | output | 1 | Limp-home output value |
| limp_oe_o | output | 1 | Limp-home output enable |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a lock clear and a trigger write. The bench applies both in one vector, once with a matching value and once with a wrong value. It judges the result from `lock_o` after that edge and from `cnt_o` over the next DISCH_CYC edges, where no increment may appear. The second pair is expiry and an accepted write. A directed test places the write in the exact cycle before the TIMEOUT-th edge. It then checks that `limp_o` stays low and that the next expiry lands DISCH_CYC + TIMEOUT edges later.

// File: rtl/wdg_limp_pkg.sv
package wdg_limp_pkg;
  typedef enum logic {PH_RUN = 1'b0, PH_DISCH = 1'b1} phase_e;
endpackage

// File: rtl/wd_timer.sv
module wd_timer #(
  parameter int TIMEOUT   = 64,
  parameter int DISCH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic serve_i,
  output logic run_o,
  output logic done_o,
  output logic expire_o
);
  import wdg_limp_pkg::*;

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam int DW = $clog2(DISCH_CYC + 1);
  localparam logic [TW-1:0] TLAST = TW'(TIMEOUT - 1);
  localparam logic [DW-1:0] DLAST = DW'(DISCH_CYC - 1);

  phase_e        phase_q;
  logic [TW-1:0] timer_q;
  logic [DW-1:0] dly_q;

  assign run_o    = (phase_q == PH_RUN);
  assign done_o   = armed_i && (phase_q == PH_DISCH) && (dly_q == DLAST);
  assign expire_o = armed_i && run_o && (timer_q == TLAST) && !serve_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RUN;
      timer_q <= '0;
      dly_q   <= '0;
    end else if (!armed_i) begin
      phase_q <= PH_RUN;
      timer_q <= '0;
      dly_q   <= '0;
    end else if (serve_i) begin
      phase_q <= PH_DISCH;
      timer_q <= '0;
      dly_q   <= '0;
    end else if (phase_q == PH_DISCH) begin
      if (dly_q == DLAST) begin
        phase_q <= PH_RUN;
        dly_q   <= '0;
      end else begin
        dly_q <= dly_q + 1'b1;
      end
    end else begin
      timer_q <= timer_q + 1'b1;
    end
  end
endmodule

// File: rtl/wd_trigger.sv
module wd_trigger #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             armed_i,
  input  logic             wipe_i,
  input  logic             run_i,
  input  logic             done_i,
  input  logic             trig_we_i,
  input  logic [CNT_W-1:0] trig_val_i,
  input  logic             lock_clr_i,
  output logic             serve_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lock_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             lock_q;
  logic             match, bad_wr;

  assign match   = (trig_val_i == cnt_q);
  assign serve_o = armed_i && run_i && trig_we_i && !lock_q && match;
  assign bad_wr  = armed_i && trig_we_i && !match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '1;
      lock_q <= 1'b0;
    end else if (!armed_i || wipe_i) begin
      cnt_q  <= '1;
      lock_q <= 1'b0;
    end else begin
      if (done_i) cnt_q <= cnt_q + 1'b1;
      // a wrong write wins over a same-cycle clear
      if (bad_wr)          lock_q <= 1'b1;
      else if (lock_clr_i) lock_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/wd_limp_latch.sv
module wd_limp_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic expire_i,
  output logic limp_o
);
  logic limp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        limp_q <= 1'b0;
    else if (!enable_i) limp_q <= 1'b0;
    else if (expire_i)  limp_q <= 1'b1;
  end

  assign limp_o = limp_q;
endmodule

// File: rtl/wdg_limp.sv
module wdg_limp #(
  parameter int CNT_W     = 2,
  parameter int TIMEOUT   = 64,
  parameter int DISCH_CYC = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             trig_we_i,
  input  logic [CNT_W-1:0] trig_val_i,
  input  logic             lock_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             lock_o,
  output logic             limp_o,
  output logic             limp_oe_o
);
  logic limp_q, armed, serve, run, done, expire;

  assign armed = enable_i && !limp_q;

  wd_timer #(.TIMEOUT(TIMEOUT), .DISCH_CYC(DISCH_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .armed_i  (armed),
    .serve_i  (serve),
    .run_o    (run),
    .done_o   (done),
    .expire_o (expire)
  );

  wd_trigger #(.CNT_W(CNT_W)) u_trig (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .armed_i    (armed),
    .wipe_i     (expire),
    .run_i      (run),
    .done_i     (done),
    .trig_we_i  (trig_we_i),
    .trig_val_i (trig_val_i),
    .lock_clr_i (lock_clr_i),
    .serve_o    (serve),
    .cnt_o      (cnt_o),
    .lock_o     (lock_o)
  );

  wd_limp_latch u_limp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .expire_i (expire),
    .limp_o   (limp_q)
  );

  assign limp_o    = limp_q;
  assign limp_oe_o = limp_q;
endmodule

// File: rtl/wdg_limp_chk.sv
module wdg_limp_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             trig_we_i,
  input logic [CNT_W-1:0] trig_val_i,
  input logic             lock_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             lock_o,
  input logic             limp_o,
  input logic             limp_oe_o
);
  logic [CNT_W-1:0] cnt_inc;
  assign cnt_inc = cnt_o + 1'b1;

  // R8
  disable_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!limp_o && !lock_o && cnt_o == '1));

  // R7
  limp_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limp_o && enable_i |=> limp_o);

  // R3
  bad_write_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !limp_o && trig_we_i && trig_val_i != cnt_o |=> (lock_o || limp_o));

  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i && !limp_o |=> (limp_o || cnt_o == $past(cnt_o) || cnt_o == $past(cnt_inc)));

  // R7
  limp_defaults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limp_o |-> (cnt_o == '1 && !lock_o));

  // R10
  limp_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    limp_oe_o == limp_o);

  // R6
  limp_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !limp_o && !enable_i |=> !limp_o);

  // R5
  clear_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && lock_clr_i && !trig_we_i |=> !lock_o);
endmodule

bind wdg_limp wdg_limp_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enable_i   (enable_i),
  .trig_we_i  (trig_we_i),
  .trig_val_i (trig_val_i),
  .lock_clr_i (lock_clr_i),
  .cnt_o      (cnt_o),
  .lock_o     (lock_o),
  .limp_o     (limp_o),
  .limp_oe_o  (limp_oe_o)
);

// File: tb/wdg_limp_test.sv
`timescale 1ns/1ps
module wdg_limp_test;
  localparam int T  = 64;
  localparam int D  = 3;
  localparam int NV = 24;

  // {en, we, val[1:0], clr, cnt[1:0], lock, limp}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_00_0_11_0_0,  // R1
    9'b1_0_00_0_11_0_0,  // R1
    9'b1_1_11_0_11_0_0,  // R2 serve
    9'b1_0_00_0_11_0_0,
    9'b1_0_00_0_11_0_0,
    9'b1_0_00_0_00_0_0,  // R2 wrap after D edges
    9'b1_1_10_0_00_1_0,  // R3 wrong value
    9'b1_1_00_0_00_1_0,  // R4 locked
    9'b1_1_00_1_00_0_0,  // R5 clear + match
    9'b1_0_00_0_00_0_0,
    9'b1_0_00_0_00_0_0,
    9'b1_0_00_0_00_0_0,  // R5 no increment
    9'b1_1_00_0_00_0_0,  // R2 serve
    9'b1_0_00_0_00_0_0,
    9'b1_0_00_0_00_0_0,
    9'b1_0_00_0_01_0_0,
    9'b1_1_11_1_01_1_0,  // R5 clear + wrong
    9'b1_0_00_1_01_0_0,  // R5 clear
    9'b1_1_01_0_01_0_0,  // R2 serve
    9'b1_1_01_0_01_0_0,  // R9 write in delay
    9'b1_0_00_0_01_0_0,
    9'b1_0_00_0_10_0_0,  // R9 single increment
    9'b1_1_00_0_10_1_0,  // R3
    9'b0_0_00_0_11_0_0   // R8
  };
  localparam string TAG [NV] = '{
    "R1","R1","R2","R2","R2","R2","R3","R4","R5","R5","R5","R5",
    "R2","R2","R2","R2","R5","R5","R2","R9","R9","R9","R3","R8"};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, we = 1'b0, clr = 1'b0;
  logic [1:0] val = 2'b00;
  logic [1:0] cnt;
  logic       lock, limp, limp_oe;
  int         n_chk = 0, n_bad = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  wdg_limp #(.CNT_W(2), .TIMEOUT(T), .DISCH_CYC(D)) uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .trig_we_i(we),
    .trig_val_i(val), .lock_clr_i(clr), .cnt_o(cnt), .lock_o(lock),
    .limp_o(limp), .limp_oe_o(limp_oe));

  task automatic check(input string req, input logic [1:0] ec,
                       input logic el, input logic ep);
    n_chk++;
    if (cnt !== ec || lock !== el || limp !== ep || limp_oe !== ep) begin
      n_bad++;
      $display("FAIL %s: cnt=%b lock=%b limp=%b oe=%b expected cnt=%b lock=%b limp=%b oe=%b",
               req, cnt, lock, limp, limp_oe, ec, el, ep, ep);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    we = 1'b0; clr = 1'b0; val = 2'b00;
  endtask

  initial begin
    cyc(2);
    check("R1", 2'b11, 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    check("R1", 2'b11, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      {en, we, val, clr} = VEC[i][8:4];
      cyc(1);
      check(TAG[i], VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end
    idle(); en = 1'b0; cyc(2);

    // R6: plain timeout
    en = 1'b1;
    cyc(T - 1);
    check("R6", 2'b11, 1'b0, 1'b0);
    cyc(1);
    check("R6", 2'b11, 1'b0, 1'b1);
    // R7: writes and clear ignored in limp-home
    we = 1'b1; val = 2'b11; cyc(1);
    check("R7", 2'b11, 1'b0, 1'b1);
    val = 2'b01; cyc(1);
    check("R7", 2'b11, 1'b0, 1'b1);
    idle(); clr = 1'b1; cyc(1); clr = 1'b0;
    cyc(20);
    check("R7", 2'b11, 1'b0, 1'b1);
    // R8, R10: release only by enable low
    en = 1'b0; cyc(1);
    check("R8", 2'b11, 1'b0, 1'b0);
    cyc(2);

    // R6: serve in the last cycle before expiry
    en = 1'b1;
    cyc(T - 1);
    we = 1'b1; val = 2'b11; cyc(1); idle();
    check("R6", 2'b11, 1'b0, 1'b0);
    cyc(D - 1);
    check("R6", 2'b11, 1'b0, 1'b0);
    cyc(1);
    check("R2", 2'b00, 1'b0, 1'b0);
    cyc(T - 1);
    check("R6", 2'b00, 1'b0, 1'b0);
    cyc(1);
    check("R6", 2'b11, 1'b0, 1'b1);
    en = 1'b0; cyc(1);
    check("R8", 2'b11, 1'b0, 1'b0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule